// File: doc/BRIEF.md
# Half-Bridge Deadtime Pulse Generator

This block produces the two complementary gate-drive commands of a half-bridge from a digital model of a sawtooth oscillator. A charge counter stands in for the rising ramp and sets how long the active output stays high. A separate deadtime counter stands in for the falling ramp, and both outputs stay low while it runs. A toggle bit hands alternate active phases to the low-side and high-side outputs, so each output gets the same share of every period.

The charge length starts from a short value when the block is enabled, which gives a high start frequency. It then steps once per cycle toward a target length and holds there. A load request restarts the ramp from the start value at the next cycle boundary. The first active phase after enabling always goes to the low side, so the high-side bootstrap supply has charged before the high side is driven. Protection logic elsewhere uses two strobes: one marks the start of every active phase, and one marks the falling edge of each low-side pulse.

Top module: `hb_pulse_gen`

## Requirements
- R1: While reset is held, and while `en` is low, `lo_o`, `ho_o`, `cyc_stb_o` and `lo_fall_stb_o` are all 0.
- R2: After the clock edge that samples `en` high from the idle state, `lo_o` goes high at once for the start length, with `ho_o` low.
- R3: Active phases alternate between the two outputs in the order LO, HO, LO, HO, and so on.
- R4: Each active phase is followed by a deadtime of `dead_i` cycles with both outputs low. `dead_i` is sampled when the deadtime begins, and a value of 0 acts as 1.
- R5: The first active phase lasts `start_i` cycles. At each cycle boundary the length moves by `step_i` toward `target_i`, stops at `target_i` without passing it, and then holds. This works for ramps up and for ramps down.
- R6: A one-cycle pulse on `load_i` is held pending. At the next cycle boundary the active length returns to `start_i`, and the ramp then continues from there. The length never changes inside a cycle.
- R7: Dropping `en` forces both outputs low in the same cycle and returns the block to idle. Enabling it again restarts with an LO phase of the start length.
- R8: `lo_o` and `ho_o` are never high together.
- R9: `cyc_stb_o` is high only in the first cycle of each active phase. `lo_fall_stb_o` is high only in the first deadtime cycle that follows an LO phase.
- R10: A `start_i` or `target_i` value of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable; low means undervoltage or fault |
| load_i | input | 1 | Request to restart the ramp from `start_i` at the next boundary |
| start_i | input | CNT_W | Active-phase length at enable or after a load |
| target_i | input | CNT_W | Active-phase length the ramp settles at |
| step_i | input | CNT_W | Change in length per cycle |
| dead_i | input | CNT_W | Deadtime length in clock cycles |
| lo_o | output | 1 | Low-side gate command |
| ho_o | output | 1 | High-side gate command |
| cyc_stb_o | output | 1 | First cycle of every active phase |
| lo_fall_stb_o | output | 1 | First deadtime cycle after an LO phase |

## Verification
The active phase, the deadtime counter and the steering bit all change on the first clock edge after the condition that triggers them, and the outputs decode those registers. The bench therefore sets `en` on a falling edge and expects `lo_o` high at the next falling edge. It then measures every high run and every gap by sampling at each falling edge, and compares each run length with a ramp sequence it works out for itself. A load request shows up only in the phase after the next boundary, so the expected sequence restarts one phase after the pulse. The drop of `en` is the only change expected without a clock edge, and the bench checks it one time step after driving it.

// File: rtl/hb_pkg.sv
package hb_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CHG  = 2'd1,
        PH_DEAD = 2'd2
    } phase_e;

    // steering: 0 selects the low side, 1 the high side
    localparam logic SIDE_LO = 1'b0;
    localparam logic SIDE_HO = 1'b1;
endpackage

// File: rtl/hb_ramp.sv
module hb_ramp #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             begin_i,
    input  logic             bound_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] start_i,
    input  logic [CNT_W-1:0] target_i,
    input  logic [CNT_W-1:0] step_i,
    output logic [CNT_W-1:0] period_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] per;
        logic             pend;
    } ramp_s;

    ramp_s r_q, r_d;
    logic [CNT_W-1:0] start_eff, tgt_eff, stepped;
    logic [CNT_W:0]   up_sum;

    always_comb begin
        start_eff = (start_i == '0) ? ONE : start_i;
        tgt_eff   = (target_i == '0) ? ONE : target_i;
        up_sum    = {1'b0, r_q.per} + {1'b0, step_i};
        stepped   = r_q.per;
        if (r_q.per < tgt_eff) begin
            stepped = (up_sum >= {1'b0, tgt_eff}) ? tgt_eff : up_sum[CNT_W-1:0];
        end else if (r_q.per > tgt_eff) begin
            stepped = ((r_q.per - tgt_eff) <= step_i) ? tgt_eff : (r_q.per - step_i);
        end

        r_d = r_q;
        if (!en) begin
            r_d.pend = 1'b0;
        end else if (begin_i) begin
            r_d.per  = start_eff;
            r_d.pend = load_i;
        end else if (bound_i) begin
            r_d.per  = r_q.pend ? start_eff : stepped;
            r_d.pend = load_i;
        end else if (load_i) begin
            r_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{per: ONE, pend: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign period_o = r_q.per;

    // the length only moves at enable or at a cycle boundary (R6)
    p_hold_between_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!begin_i && !bound_i) |=> $stable(period_o));

    // an upward step never passes the target (R5)
    p_no_overshoot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bound_i && !r_q.pend && (period_o < tgt_eff)) |=> (period_o <= $past(tgt_eff)));

    // the length is never zero (R10)
    p_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        period_o != '0);
endmodule

// File: rtl/hb_phase.sv
module hb_phase
    import hb_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] dead_i,
    output logic             chg_o,
    output logic             side_o,
    output logic             first_chg_o,
    output logic             first_dead_o,
    output logic             begin_o,
    output logic             bound_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] dcnt;
        logic [CNT_W-1:0] dlen;
        logic             side;
    } phs_s;

    phs_s s_q, s_d;
    logic [CNT_W-1:0] dead_eff;

    always_comb begin
        dead_eff = (dead_i == '0) ? ONE : dead_i;
        begin_o  = en && (s_q.ph == PH_IDLE);
        bound_o  = en && (s_q.ph == PH_DEAD) && (s_q.dcnt == s_q.dlen - ONE);

        s_d = s_q;
        if (!en) begin
            s_d.ph   = PH_IDLE;
            s_d.cnt  = '0;
            s_d.dcnt = '0;
            s_d.side = SIDE_LO;
        end else begin
            unique case (s_q.ph)
                PH_IDLE: begin
                    s_d.ph   = PH_CHG;
                    s_d.cnt  = '0;
                    s_d.side = SIDE_LO;
                end
                PH_CHG: begin
                    if (s_q.cnt == period_i - ONE) begin
                        s_d.ph   = PH_DEAD;
                        s_d.dcnt = '0;
                        s_d.dlen = dead_eff;
                    end else begin
                        s_d.cnt = s_q.cnt + ONE;
                    end
                end
                PH_DEAD: begin
                    if (bound_o) begin
                        s_d.ph   = PH_CHG;
                        s_d.cnt  = '0;
                        s_d.side = ~s_q.side;
                    end else begin
                        s_d.dcnt = s_q.dcnt + ONE;
                    end
                end
                default: s_d.ph = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_IDLE, cnt: '0, dcnt: '0, dlen: ONE, side: SIDE_LO};
        end else begin
            s_q <= s_d;
        end
    end

    assign chg_o        = (s_q.ph == PH_CHG);
    assign side_o       = s_q.side;
    assign first_chg_o  = (s_q.ph == PH_CHG) && (s_q.cnt == '0);
    assign first_dead_o = (s_q.ph == PH_DEAD) && (s_q.dcnt == '0);

    // enabling from idle opens a low-side phase (R2)
    p_first_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
        begin_o |=> (chg_o && side_o == SIDE_LO));

    // each boundary hands the next phase to the other side (R3)
    p_alternate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bound_o |=> (chg_o && side_o != $past(side_o)));

    // disabling returns to idle (R7)
    p_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (s_q.ph == PH_IDLE));

    // the active length seen by the phase counter is never zero (R10)
    p_period_ok_r10: assert property (@(posedge clk) disable iff (!rst_n)
        chg_o |-> (period_i != '0));
endmodule

// File: rtl/hb_pulse_gen.sv
module hb_pulse_gen
    import hb_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             load_i,
    input  logic [CNT_W-1:0] start_i,
    input  logic [CNT_W-1:0] target_i,
    input  logic [CNT_W-1:0] step_i,
    input  logic [CNT_W-1:0] dead_i,
    output logic             lo_o,
    output logic             ho_o,
    output logic             cyc_stb_o,
    output logic             lo_fall_stb_o
);
    logic [CNT_W-1:0] period;
    logic chg, side, first_chg, first_dead, begin_p, bound_p;

    hb_ramp #(.CNT_W(CNT_W)) u_ramp (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .begin_i  (begin_p),
        .bound_i  (bound_p),
        .load_i   (load_i),
        .start_i  (start_i),
        .target_i (target_i),
        .step_i   (step_i),
        .period_o (period)
    );

    hb_phase #(.CNT_W(CNT_W)) u_phase (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (en),
        .period_i     (period),
        .dead_i       (dead_i),
        .chg_o        (chg),
        .side_o       (side),
        .first_chg_o  (first_chg),
        .first_dead_o (first_dead),
        .begin_o      (begin_p),
        .bound_o      (bound_p)
    );

    // en gates the outputs directly so a disable acts within the cycle
    assign lo_o          = en && chg && (side == SIDE_LO);
    assign ho_o          = en && chg && (side == SIDE_HO);
    assign cyc_stb_o     = en && first_chg;
    assign lo_fall_stb_o = en && first_dead && (side == SIDE_LO);

    // both gates are never on together (R8)
    p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(lo_o && ho_o));

    // a phase strobe always coincides with a driven output (R9)
    p_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_stb_o |-> $onehot({lo_o, ho_o}));

    // the low-side falling strobe follows a low-side pulse (R9)
    p_lo_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lo_fall_stb_o |-> ($past(lo_o) && !lo_o && !ho_o));
endmodule

// File: tb/hb_pulse_gen_bench.sv
module hb_pulse_gen_bench;
    localparam int W    = 12;
    localparam int NPH  = 6;
    localparam int NVEC = 6;
    // columns: start, target, step, dead, phase in which load is pulsed (-1 none)
    localparam int VEC [NVEC][5] = '{
        '{3, 9, 2, 2, -1},
        '{12, 5, 3, 1, -1},
        '{6, 6, 1, 3, -1},
        '{0, 2, 1, 0, -1},
        '{4, 10, 3, 2, 2},
        '{2, 20, 50, 1, -1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic load_i = 1'b0;
    logic [W-1:0] start_i = '0, target_i = '0, step_i = '0, dead_i = '0;
    logic lo_o, ho_o, cyc_stb_o, lo_fall_stb_o;
    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    hb_pulse_gen #(.CNT_W(W)) u_hb_pulse_gen (
        .clk(clk), .rst_n(rst_n), .en(en), .load_i(load_i),
        .start_i(start_i), .target_i(target_i), .step_i(step_i), .dead_i(dead_i),
        .lo_o(lo_o), .ho_o(ho_o), .cyc_stb_o(cyc_stb_o), .lo_fall_stb_o(lo_fall_stb_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_len(input int s, input int t, input int st,
                                   input int ldph, input int ph);
        int p = (s < 1) ? 1 : s;
        int tt = (t < 1) ? 1 : t;
        int k = (ldph >= 0 && ph > ldph) ? ph - ldph - 1 : ph;
        for (int i = 0; i < k; i++) begin
            if (p < tt) p = (p + st >= tt) ? tt : p + st;
            else if (p > tt) p = (p - tt <= st) ? tt : p - st;
        end
        return p;
    endfunction

    task automatic run_vec(input int s, input int t, input int st, input int d, input int ldph);
        int dexp = (d < 1) ? 1 : d;
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        start_i = W'(s); target_i = W'(t); step_i = W'(st); dead_i = W'(d);
        en = 1'b1;
        @(negedge clk);
        for (int ph = 0; ph < NPH; ph++) begin
            bit side = ph[0];
            int w = 0, dl = 0, other = 0;
            int el = exp_len(s, t, st, ldph, ph);
            chk((side ? ho_o : lo_o) == 1'b1, (ph == 0) ? "R2 first side" : "R3 side", int'(side ? ho_o : lo_o), 1);
            chk(cyc_stb_o == 1'b1, "R9 cyc_stb", int'(cyc_stb_o), 1);
            if (ph == ldph) load_i = 1'b1;
            while ((side ? ho_o : lo_o) && w < 5000) begin
                if (side ? lo_o : ho_o) other++;
                if (w > 0 && cyc_stb_o) other++;
                w++;
                @(negedge clk);
                load_i = 1'b0;
            end
            chk(w == el, "R5/R6 active length", w, el);
            chk(other == 0, "R8/R9 other side or stray strobe", other, 0);
            chk(lo_fall_stb_o == !side, "R9 lo_fall_stb", int'(lo_fall_stb_o), int'(!side));
            while (!lo_o && !ho_o && dl < 5000) begin
                dl++;
                @(negedge clk);
            end
            chk(dl == dexp, "R4 deadtime", dl, dexp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        en = 1'b1;
        repeat (3) @(negedge clk);
        chk(!lo_o && !ho_o && !cyc_stb_o && !lo_fall_stb_o, "R1 reset",
            int'({lo_o, ho_o, cyc_stb_o, lo_fall_stb_o}), 0);
        en = 1'b0;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!lo_o && !ho_o && !cyc_stb_o && !lo_fall_stb_o, "R1 disabled",
            int'({lo_o, ho_o, cyc_stb_o, lo_fall_stb_o}), 0);

        for (int v = 0; v < NVEC; v++)
            run_vec(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4]);

        // R7: drop enable in the middle of an LO phase, then restart
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        start_i = 12'd8; target_i = 12'd8; step_i = 12'd1; dead_i = 12'd2;
        en = 1'b1;
        repeat (3) @(negedge clk);
        chk(lo_o == 1'b1, "R7 LO before drop", int'(lo_o), 1);
        en = 1'b0;
        #1;
        chk(!lo_o && !ho_o, "R7 same-cycle low", int'({lo_o, ho_o}), 0);
        repeat (4) @(negedge clk);
        chk(!lo_o && !ho_o && !cyc_stb_o, "R7 stays idle", int'({lo_o, ho_o, cyc_stb_o}), 0);
        en = 1'b1;
        begin
            int w = 0;
            @(negedge clk);
            chk(lo_o && !ho_o, "R7 restart on LO", int'({lo_o, ho_o}), 2);
            while (lo_o && w < 5000) begin
                w++;
                @(negedge clk);
            end
            chk(w == 8, "R7 restart length", w, 8);
        end
        en = 1'b0;
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule